// File: doc/BRIEF.md
# Line Result Holding Register with Read-Only I2C Port

This block keeps the five-byte result of the most recent error-free decoded data line and hands it to a host over a read-only I2C slave. A line decoder writes every finished line into a staging bank and raises a one-cycle done pulse together with an error flag. A line without an error is then copied into an output bank. The host reads that bank over the bus.

While the slave is addressed, the copy into the output bank waits. The output bank therefore never changes inside a read transaction. The copy happens on the first cycle after the next start or stop condition. A new-data flag marks whether the output bank holds valid data that has not been read yet. Once the data has been read, the flag clears. From then on, every byte returned on the bus is 8'hFF until another error-free line has been transferred.

SCL and SDA are first synchronised to the system clock. The block drives the bus only through an open-drain enable: a 1 on `sda_oe` pulls SDA low.

Top module: `line_result_i2c`

## Requirements
- R1: On a `line_done` pulse with `line_err` low, `line_data` is taken into the staging bank and moved to the output bank. A following read then returns it. A pulse with `line_err` high never reaches the output bank.
- R2: While the slave is addressed (from a matching read address until the next start or stop), the output bank stays unchanged. A line that arrives during a transaction is served only after that transaction ends.
- R3: Bytes are sent MSB first in this order: `line_data[39:32]`, `[31:24]`, `[23:16]`, `[15:8]`, then `[7:0]`. The decoder packs word 11 into the top byte, followed by words 12, 13 and 14, with word 5 in the bottom byte.
- R4: The data counts as consumed in either of two cases: the fifth byte has been shifted out, or a start or stop ends a read in which at least one whole byte was sent. After that, reads return 8'hFF.
- R5: While no unread valid data is held, including after reset, every byte read is 8'hFF.
- R6: Valid unread data stays available even if later lines arrive with `line_err` high.
- R7: Only the 7-bit address `DEV_ADDR` with the read bit set (1) is acknowledged. A write-direction or non-matching address gets no acknowledge: `sda_oe` stays 0.
- R8: Any byte after the fifth within one transaction is 8'hFF.
- R9: Out of reset, `sda_oe` is 0 and no valid data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_data | input | 40 | Decoded line result, first byte served in bits 39:32 |
| line_done | input | 1 | One-cycle pulse: a line has finished |
| line_err | input | 1 | Error seen in the finished line, valid with `line_done` |
| scl_in | input | 1 | I2C clock from the bus |
| sda_in | input | 1 | I2C data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The output bank is updated two clock edges after `line_done`: one edge to latch the pending flag and one to make the copy. Each bus phase in the bench lasts five clocks, so lines are fed at least four clocks before a read begins. Bus responses reach `sda_oe` three clocks after the SCL edge that causes them: two synchroniser stages and one register. The bench therefore samples SDA two clocks into the SCL high phase, when the response has long settled. A transfer held back during a transaction is checked by the data of the very next transaction, which begins well after the one-cycle copy that follows the stop.

// File: rtl/line_result_i2c.sv
module line_result_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter int         NBYTES   = 5,
  localparam int        W        = 8 * NBYTES,
  localparam int        CW       = $clog2(NBYTES + 2)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_data,
  input  logic         line_done,
  input  logic         line_err,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         sda_oe
);

  localparam logic [CW-1:0] LASTB = CW'(NBYTES - 1);
  localparam logic [CW-1:0] SATB  = CW'(NBYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;

  logic [W-1:0]  stage_q, out_q;
  logic          pend_q, nd_q, addressed_q;
  st_t           st_q;
  logic [2:0]    bit_q;
  logic [7:0]    sr_q;
  logic [CW-1:0] byte_q;
  logic          got8_q, ack_ok_q;

  wire xfer    = pend_q & ~line_done & ~addressed_q;
  wire consume = addressed_q &
                 ((((start_c | stop_c) & (byte_q != '0))) |
                  ((st_q == S_TX) & scl_fall & (bit_q == 3'd7) & (byte_q == LASTB)));

  function automatic logic [7:0] pick(input logic [CW-1:0] idx);
    logic [W-1:0] sh;
    sh = out_q << {idx, 3'b000};
    return (nd_q && idx <= LASTB) ? sh[W-1 -: 8] : 8'hFF;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
      pend_q  <= 1'b0;
    end else if (line_done) begin
      stage_q <= line_data;
      pend_q  <= ~line_err;
    end else if (xfer) begin
      out_q  <= stage_q;
      pend_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        nd_q <= 1'b0;
    else if (xfer)     nd_q <= 1'b1;
    else if (consume)  nd_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q        <= S_IDLE;
      bit_q       <= '0;
      sr_q        <= '0;
      byte_q      <= '0;
      got8_q      <= 1'b0;
      ack_ok_q    <= 1'b0;
      addressed_q <= 1'b0;
      sda_oe      <= 1'b0;
    end else if (start_c) begin
      st_q        <= S_ADDR;
      bit_q       <= '0;
      got8_q      <= 1'b0;
      addressed_q <= 1'b0;
      sda_oe      <= 1'b0;
    end else if (stop_c) begin
      st_q        <= S_IDLE;
      addressed_q <= 1'b0;
      sda_oe      <= 1'b0;
    end else begin
      case (st_q)
        S_ADDR: begin
          if (scl_rise) begin
            sr_q  <= {sr_q[6:0], sda_s};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) got8_q <= 1'b1;
          end else if (scl_fall && got8_q) begin
            got8_q <= 1'b0;
            if (sr_q == {DEV_ADDR, 1'b1}) begin
              st_q        <= S_AACK;
              sda_oe      <= 1'b1;
              addressed_q <= 1'b1;
              byte_q      <= '0;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            sr_q   <= pick(byte_q);
            sda_oe <= ~pick(byte_q)[7];
            bit_q  <= '0;
            st_q   <= S_TX;
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              sda_oe <= 1'b0;
              st_q   <= S_MACK;
              if (byte_q != SATB) byte_q <= byte_q + 1'b1;
            end else begin
              sr_q   <= {sr_q[6:0], 1'b1};
              sda_oe <= ~sr_q[6];
              bit_q  <= bit_q + 3'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) ack_ok_q <= ~sda_s;
          else if (scl_fall) begin
            if (ack_ok_q) begin
              sr_q   <= pick(byte_q);
              sda_oe <= ~pick(byte_q)[7];
              bit_q  <= '0;
              st_q   <= S_TX;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

endmodule

module line_result_i2c_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sda_oe,
  input logic         scl_s,
  input logic         addressed,
  input logic         nd,
  input logic         pend,
  input logic [W-1:0] out_bank
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!sda_oe && !nd));

  // R2
  bank_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addressed) |-> $stable(out_bank));

  // R1
  valid_from_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nd) |-> $past(pend));

  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nd) |-> $past(addressed));

  // R7
  drive_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

endmodule

bind line_result_i2c line_result_i2c_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .addressed(addressed_q), .nd(nd_q), .pend(pend_q), .out_bank(out_q)
);

// File: tb/test_line_result_i2c.sv
module test_line_result_i2c;

  localparam logic [6:0] ADDR = 7'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] line_data = '0;
  logic        line_done = 1'b0;
  logic        line_err = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  line_result_i2c #(.DEV_ADDR(ADDR)) i_line_result_i2c (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .line_done(line_done),
    .line_err(line_err), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(5);
    sda_m = 1'b0; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(5);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(5); scl_m = 1'b1; tick(5); scl_m = 1'b0; tick(5);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(2); b = sda_line;
    tick(3); scl_m = 1'b0; tick(5);
  endtask

  task automatic open_txn(input logic [6:0] a, input logic rw, output logic acked);
    logic b;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(i == 0 ? rw : a[i-1]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(last);
  endtask

  task automatic feed(input logic [39:0] d, input logic e);
    @(negedge clk);
    line_data = d; line_err = e; line_done = 1'b1;
    tick(1);
    line_done = 1'b0;
    tick(4);
  endtask

  task automatic read_expect(input string req, input int n, input logic [39:0] d, input logic valid);
    logic       ack;
    logic [7:0] v;
    logic [7:0] e;
    open_txn(ADDR, 1'b1, ack);
    check({req, " ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, v);
      e = (valid && i < 5) ? d[39 - 8*i -: 8] : 8'hFF;
      check($sformatf("%s byte%0d", req, i), v, e);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic        ack;
    logic [7:0]  v;
    logic [39:0] prev, d;
    logic        prev_ok;

    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R9: outputs quiet out of reset
    check("R9 oe", sda_oe, 1'b0);
    // R5: nothing valid after reset
    read_expect("R5", 5, '0, 1'b0);

    // R7: write direction and foreign address are not acknowledged
    open_txn(ADDR, 1'b0, ack);
    check("R7 write nack", ack, 1'b0);
    bus_stop();
    open_txn(ADDR ^ 7'h01, 1'b1, ack);
    check("R7 addr nack", ack, 1'b0);
    bus_stop();

    // R1 R3 R4 R5: sweep of patterns, one in three with an error
    for (int k = 0; k < 12; k++) begin
      d = 40'(64'h9E3779B97F4A7C15 * 64'(k + 1));
      feed(d, (k % 3) == 2);
      read_expect((k % 3) == 2 ? "R1 err" : "R3 order", 5, d, (k % 3) != 2);
      read_expect("R4 reread", 5, d, 1'b0);
    end

    // R6: an errored line does not disturb unread data
    prev = 40'hC0FFEE1234;
    feed(prev, 1'b0);
    feed(40'h1111111111, 1'b1);
    feed(40'h2222222222, 1'b1);
    read_expect("R6", 5, prev, 1'b1);

    // R8: bytes beyond the fifth are all ones
    feed(40'h0102030405, 1'b0);
    read_expect("R8", 7, 40'h0102030405, 1'b1);

    // R4: partial read then stop consumes the data
    feed(40'hA1B2C3D4E5, 1'b0);
    read_expect("R4 partial", 2, 40'hA1B2C3D4E5, 1'b1);
    read_expect("R4 after partial", 5, '0, 1'b0);

    // R2: a good line arriving mid-read is deferred
    prev = 40'h5566778899;
    feed(prev, 1'b0);
    open_txn(ADDR, 1'b1, ack);
    check("R2 ack", ack, 1'b1);
    rd_byte(1'b0, v);
    check("R2 byte0", v, prev[39:32]);
    feed(40'hDEADBEEF42, 1'b0);
    for (int i = 1; i < 5; i++) begin
      rd_byte(i == 4, v);
      check($sformatf("R2 held byte%0d", i), v, prev[39 - 8*i -: 8]);
    end
    bus_stop();
    read_expect("R2 after stop", 5, 40'hDEADBEEF42, 1'b1);

    // R5: once consumed, nothing left
    read_expect("R5 empty", 5, '0, 1'b0);
    check("R9 idle oe", sda_oe, 1'b0);

    prev_ok = 1'b1;
    if (prev_ok) ;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule